// File: doc/BRIEF.md
# Decimal-Adjusting ALU with Deferred Accumulator Commit

This block is the arithmetic end of an 8-bit processor datapath. On an execute strobe it computes an add, subtract, logical, rotate, complement, load or decimal-adjust result from the accumulator, an operand and the current flags. The result and the new flags are not written to the architectural accumulator straight away. They wait in a holding register and are committed on the clock edge where the sequencer marks the second state of the next instruction's fetch cycle. The accumulator write therefore overlaps that fetch.

While a result is waiting, any operation that reads the accumulator or the flags sees the waiting value, so back-to-back operations stay correct. The block also tests one of eight branch conditions against the flags and reports whether the condition holds. Opcode decoding lies outside the block. The sequencer supplies a 4-bit operation code and a 3-bit condition code.

Top module: `acc_defer_alu`

## Requirements
- R1: A synchronous active-low reset clears the committed accumulator, the committed flags and any waiting result. After reset `acc_out` and `flags_out` read zero, and a commit strobe alone leaves them at zero.
- R2: A result computed on an `exec_en` edge does not appear on `acc_out`/`flags_out` until a later edge where `fetch_t2` is high. It appears on that edge. Without `fetch_t2` the outputs hold indefinitely, and `fetch_t2` with nothing waiting changes nothing.
- R3: An operation executed while a result is waiting takes the waiting accumulator and flags as its inputs. When `exec_en` and `fetch_t2` share an edge, the older result is committed and the new one is left waiting.
- R4: Arithmetic codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow. CY is the carry out of bit 7, or the borrow for subtraction. AC is the carry out of bit 3, or the borrow from bit 4 for subtraction.
- R5: Logical codes are 4 AND, 5 XOR, 6 OR. They clear CY and AC.
- R6: Rotate codes are 8 left circular, 9 right circular, 10 left through carry, 11 right through carry. Only CY changes, taking the bit shifted out.
- R7: Code 7 compares: the flags are set as for a subtraction and the accumulator is kept. Code 13 complements the accumulator, code 14 loads the operand, and code 15 inverts CY. Codes 13 and 14 leave the flags unchanged; code 15 changes only CY.
- R8: Code 12 is the decimal adjust, first step. If the low nibble exceeds 9 or AC is set, 6 is added to the accumulator, and AC becomes the carry out of bit 3 of that addition. Otherwise AC becomes 0.
- R9: Decimal adjust, second step. If the high nibble of the intermediate value exceeds 9, or CY is set, or the first step carried out of bit 7, then 6 is added to the high nibble. CY becomes 1 if it was already set or if either step carried out of bit 7.
- R10: `cond_met` evaluates `cond_sel`: 000 Z=0, 001 Z=1, 010 CY=0, 011 CY=1, 100 P=0, 101 P=1, 110 S=0, 111 S=1.
- R11: While a result is waiting, `cond_met` is evaluated on the waiting flags, not on the committed ones.
- R12: `flags_out` is {S, Z, AC, P, CY} from bit 4 down to bit 0. For arithmetic, logical, compare and decimal-adjust codes, S is result bit 7, Z is 1 for a zero result, and P is 1 for an even number of one bits. For compare, these are taken from the difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_en | input | 1 | Compute a result this edge and leave it waiting |
| op_sel | input | 4 | Operation code |
| operand | input | 8 | Second operand |
| fetch_t2 | input | 1 | Commit strobe, fetch-cycle second state |
| cond_sel | input | 3 | Branch condition code |
| acc_out | output | 8 | Committed accumulator |
| flags_out | output | 5 | Committed flags {S,Z,AC,P,CY} |
| cond_met | output | 1 | Selected condition holds on the current flags |

## Verification
A waiting result that was dropped, or committed twice, shows on `acc_out` at the first commit edge after it. A stale forwarding path shows one commit later, as a wrong value from a chained operation. A wrong flag in the holding register shows on `cond_met` combinationally, in the same cycle as the execute edge, before any commit. Decimal-adjust step errors surface in both the accumulator and the CY/AC bits at the commit that follows the adjust.

// File: rtl/acc_alu_pkg.sv
// Shared widths, operation codes and the flag record for the deferred-commit ALU.
package acc_alu_pkg;
    localparam int WORD_W   = 8;
    localparam int NIB_W    = WORD_W / 2;
    localparam int OP_W     = 4;
    localparam int COND_W   = 3;
    localparam int FLAG_W   = 5;
    localparam int BCD_MAX  = 9;
    localparam int BCD_FIX  = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBB  = 4'd3,
        OP_AND  = 4'd4,  OP_XOR  = 4'd5,  OP_OR   = 4'd6,  OP_CMP  = 4'd7,
        OP_RLC  = 4'd8,  OP_RRC  = 4'd9,  OP_RAL  = 4'd10, OP_RAR  = 4'd11,
        OP_DADJ = 4'd12, OP_CPL  = 4'd13, OP_LOAD = 4'd14, OP_CMC  = 4'd15
    } op_t;

    // Bit 4 down to bit 0: sign, zero, half carry, parity, carry.
    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;
endpackage

// File: rtl/acc_alu_core.sv
// Arithmetic, logical, rotate and complement datapath (everything except the
// decimal adjust). Purely combinational. Assumes the caller supplies the
// forwarded accumulator and flags. Unlisted codes pass the inputs through.
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  op_t                 op,
    input  logic [WORD_W-1:0]   a,
    input  logic [WORD_W-1:0]   b,
    input  flags_t              f_in,
    output logic [WORD_W-1:0]   res,
    output flags_t              f_out
);
    localparam int XW = WORD_W + 1;
    localparam int NX = NIB_W + 1;

    logic          cin;
    logic          bin;
    logic [XW-1:0] sum_x;
    logic [XW-1:0] dif_x;
    logic [NX-1:0] sum_lo;
    logic [NX-1:0] dif_lo;

    // Wide sums and differences that yield the carry and half carry.
    always_comb begin
        cin    = (op == OP_ADC) ? f_in.cy : 1'b0;
        bin    = (op == OP_SBB) ? f_in.cy : 1'b0;
        sum_x  = {1'b0, a} + {1'b0, b} + XW'(cin);
        dif_x  = {1'b0, a} - {1'b0, b} - XW'(bin);
        sum_lo = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + NX'(cin);
        dif_lo = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - NX'(bin);
    end

    logic [WORD_W-1:0] val;
    logic              upd_szp;

    // Select the result and the flag updates for the requested operation.
    always_comb begin
        res     = a;
        f_out   = f_in;
        val     = a;
        upd_szp = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                res = sum_x[WORD_W-1:0];  val = res;  upd_szp = 1'b1;
                f_out.cy = sum_x[WORD_W]; f_out.ac = sum_lo[NIB_W];
            end
            OP_SUB, OP_SBB: begin
                res = dif_x[WORD_W-1:0];  val = res;  upd_szp = 1'b1;
                f_out.cy = dif_x[WORD_W]; f_out.ac = dif_lo[NIB_W];
            end
            OP_CMP: begin
                val = dif_x[WORD_W-1:0];  upd_szp = 1'b1;
                f_out.cy = dif_x[WORD_W]; f_out.ac = dif_lo[NIB_W];
            end
            OP_AND: begin
                res = a & b; val = res; upd_szp = 1'b1;
                f_out.cy = 1'b0; f_out.ac = 1'b0;
            end
            OP_XOR: begin
                res = a ^ b; val = res; upd_szp = 1'b1;
                f_out.cy = 1'b0; f_out.ac = 1'b0;
            end
            OP_OR: begin
                res = a | b; val = res; upd_szp = 1'b1;
                f_out.cy = 1'b0; f_out.ac = 1'b0;
            end
            OP_RLC: begin
                res = {a[WORD_W-2:0], a[WORD_W-1]}; f_out.cy = a[WORD_W-1];
            end
            OP_RRC: begin
                res = {a[0], a[WORD_W-1:1]};        f_out.cy = a[0];
            end
            OP_RAL: begin
                res = {a[WORD_W-2:0], f_in.cy};     f_out.cy = a[WORD_W-1];
            end
            OP_RAR: begin
                res = {f_in.cy, a[WORD_W-1:1]};     f_out.cy = a[0];
            end
            OP_CPL:  res = ~a;
            OP_LOAD: res = b;
            OP_CMC:  f_out.cy = ~f_in.cy;
            default: res = a;
        endcase
        if (upd_szp) begin
            f_out.s = val[WORD_W-1];
            f_out.z = (val == '0);
            f_out.p = ~^val;
        end
    end
endmodule

// File: rtl/acc_dec_adjust.sv
// Two-step decimal correction of the accumulator after a BCD add. Purely
// combinational. Assumes the incoming AC/CY are the flags left by the add.
module acc_dec_adjust
    import acc_alu_pkg::*;
(
    input  logic [WORD_W-1:0] a_in,
    input  logic              ac_in,
    input  logic              cy_in,
    output logic [WORD_W-1:0] a_out,
    output logic              ac_out,
    output logic              cy_out
);
    localparam int XW = WORD_W + 1;
    localparam int NX = NIB_W + 1;

    logic              lo_fix;
    logic              hi_fix;
    logic [NX-1:0]     lo_sum;
    logic [XW-1:0]     step1;
    logic [XW-1:0]     step2;
    logic [WORD_W-1:0] mid;

    // First step: correct the low digit, noting carries out of bit 3 and bit 7.
    always_comb begin
        lo_fix = (a_in[NIB_W-1:0] > NIB_W'(BCD_MAX)) || ac_in;
        lo_sum = {1'b0, a_in[NIB_W-1:0]} + NX'(BCD_FIX);
        step1  = {1'b0, a_in} + (lo_fix ? XW'(BCD_FIX) : '0);
        mid    = step1[WORD_W-1:0];
        ac_out = lo_fix & lo_sum[NIB_W];
    end

    // Second step: correct the high digit and accumulate the carry.
    always_comb begin
        hi_fix = (mid[WORD_W-1:NIB_W] > NIB_W'(BCD_MAX)) || cy_in || step1[WORD_W];
        step2  = {1'b0, mid} + (hi_fix ? (XW'(BCD_FIX) << NIB_W) : '0);
        a_out  = step2[WORD_W-1:0];
        cy_out = cy_in | step1[WORD_W] | step2[WORD_W];
    end

    // A value that is already valid BCD with clear carries passes unchanged.
    always_comb begin
        if (!ac_in && !cy_in && (a_in[NIB_W-1:0] <= NIB_W'(BCD_MAX))
            && (a_in[WORD_W-1:NIB_W] <= NIB_W'(BCD_MAX))) begin
            // R8
            bcd_pass_chk: assert (a_out == a_in && !cy_out && !ac_out);
        end
    end
endmodule

// File: rtl/acc_cond_eval.sv
// Tests one of eight branch conditions against a flag record. Purely
// combinational. Assumes code bits [2:1] pick the flag and bit 0 its polarity.
module acc_cond_eval
    import acc_alu_pkg::*;
(
    input  flags_t            flg,
    input  logic [COND_W-1:0] cc,
    output logic              met
);
    logic sel_flag;

    // Pick the tested flag, then compare it with the wanted polarity.
    always_comb begin
        case (cc[COND_W-1:1])
            2'd0:    sel_flag = flg.z;
            2'd1:    sel_flag = flg.cy;
            2'd2:    sel_flag = flg.p;
            default: sel_flag = flg.s;
        endcase
        met = cc[0] ? sel_flag : ~sel_flag;
    end
endmodule

// File: rtl/acc_defer_alu.sv
// Top of the deferred-commit ALU. Each execute edge computes a result and leaves
// it waiting. A fetch-T2 strobe commits the waiting result to the architectural
// accumulator and flags. Reads of the accumulator and flags (by the next operation
// and by the condition test) are forwarded from the waiting copy.
// Assumes the sequencer raises fetch_t2 once per instruction fetch.
module acc_defer_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [WORD_W-1:0] operand,
    input  logic              fetch_t2,
    input  logic [COND_W-1:0] cond_sel,
    output logic [WORD_W-1:0] acc_out,
    output logic [FLAG_W-1:0] flags_out,
    output logic              cond_met
);
    logic [WORD_W-1:0] acc_q;
    flags_t            flg_q;
    logic [WORD_W-1:0] pend_acc;
    flags_t            pend_flg;
    logic              pend_vld;

    logic [WORD_W-1:0] a_eff;
    flags_t            f_eff;
    logic              commit;
    op_t               op;

    // Forward the waiting copy to every reader of the accumulator and flags.
    always_comb begin
        a_eff  = pend_vld ? pend_acc : acc_q;
        f_eff  = pend_vld ? pend_flg : flg_q;
        commit = fetch_t2 & pend_vld;
        op     = op_t'(op_sel);
    end

    logic [WORD_W-1:0] core_res;
    flags_t            core_flg;
    logic [WORD_W-1:0] dadj_res;
    logic              dadj_ac;
    logic              dadj_cy;

    acc_alu_core u_core (
        .op    (op),
        .a     (a_eff),
        .b     (operand),
        .f_in  (f_eff),
        .res   (core_res),
        .f_out (core_flg)
    );

    acc_dec_adjust u_dadj (
        .a_in   (a_eff),
        .ac_in  (f_eff.ac),
        .cy_in  (f_eff.cy),
        .a_out  (dadj_res),
        .ac_out (dadj_ac),
        .cy_out (dadj_cy)
    );

    acc_cond_eval u_cond (
        .flg (f_eff),
        .cc  (cond_sel),
        .met (cond_met)
    );

    logic [WORD_W-1:0] new_acc;
    flags_t            new_flg;

    // Merge the decimal-adjust path with the general datapath.
    always_comb begin
        if (op == OP_DADJ) begin
            new_acc    = dadj_res;
            new_flg.s  = dadj_res[WORD_W-1];
            new_flg.z  = (dadj_res == '0);
            new_flg.ac = dadj_ac;
            new_flg.p  = ~^dadj_res;
            new_flg.cy = dadj_cy;
        end else begin
            new_acc = core_res;
            new_flg = core_flg;
        end
    end

    // Architectural accumulator and flags: written only at a fetch-T2 commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            flg_q <= '0;
        end else if (commit) begin
            acc_q <= pend_acc;
            flg_q <= pend_flg;
        end
    end

    // Holding register: filled by an execute, drained by a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_acc <= '0;
            pend_flg <= '0;
            pend_vld <= 1'b0;
        end else if (exec_en) begin
            pend_acc <= new_acc;
            pend_flg <= new_flg;
            pend_vld <= 1'b1;
        end else if (commit) begin
            pend_vld <= 1'b0;
        end
    end

    assign acc_out   = acc_q;
    assign flags_out = flg_q;

    // R2
    commit_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_t2 && pend_vld) |=> (acc_out == $past(pend_acc)) && (flags_out == $past(pend_flg)));

    // R2
    hold_arch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_t2 && pend_vld) |=> $stable(acc_out) && $stable(flags_out));

    // R3
    drain_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_t2 && pend_vld && !exec_en) |=> !pend_vld);
endmodule

// File: tb/acc_defer_alu_test.sv
module acc_defer_alu_test;
    import acc_alu_pkg::*;

    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              exec_en;
    logic [OP_W-1:0]   op_sel;
    logic [WORD_W-1:0] operand;
    logic              fetch_t2;
    logic [COND_W-1:0] cond_sel;
    logic [WORD_W-1:0] acc_out;
    logic [FLAG_W-1:0] flags_out;
    logic              cond_met;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    acc_defer_alu uut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
        .operand(operand), .fetch_t2(fetch_t2), .cond_sel(cond_sel),
        .acc_out(acc_out), .flags_out(flags_out), .cond_met(cond_met)
    );

    // {start A, carry in, op, operand, expected A, expected {S,Z,AC,P,CY}}
    localparam int NV = 14;
    localparam logic [33:0] VEC [NV] = '{
        {8'h3A, 1'b0, 4'd0,  8'hC6, 8'h00, 5'b01111},
        {8'h10, 1'b1, 4'd1,  8'h05, 8'h16, 5'b00000},
        {8'h05, 1'b0, 4'd2,  8'h06, 8'hFF, 5'b10111},
        {8'h20, 1'b1, 4'd3,  8'h10, 8'h0F, 5'b00110},
        {8'hF0, 1'b0, 4'd4,  8'h3C, 8'h30, 5'b00010},
        {8'h55, 1'b0, 4'd5,  8'h55, 8'h00, 5'b01010},
        {8'h80, 1'b0, 4'd6,  8'h01, 8'h81, 5'b10010},
        {8'h42, 1'b0, 4'd7,  8'h42, 8'h42, 5'b01010},
        {8'h81, 1'b0, 4'd8,  8'h00, 8'h03, 5'b10011},
        {8'h01, 1'b0, 4'd9,  8'h00, 8'h80, 5'b00001},
        {8'h80, 1'b0, 4'd10, 8'h00, 8'h00, 5'b10001},
        {8'h01, 1'b1, 4'd11, 8'h00, 8'h80, 5'b00001},
        {8'h3C, 1'b0, 4'd13, 8'h00, 8'hC3, 5'b00010},
        {8'h00, 1'b1, 4'd15, 8'h00, 8'h00, 5'b01010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic exec(input op_t op, input logic [WORD_W-1:0] d);
        @(negedge clk);
        exec_en = 1'b1; op_sel = op; operand = d;
        @(negedge clk);
        exec_en = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        fetch_t2 = 1'b1;
        @(negedge clk);
        fetch_t2 = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Load A and force a known flag state: AND 0xFF clears CY and AC.
    task automatic prime(input logic [WORD_W-1:0] a, input logic cy);
        exec(OP_LOAD, a); commit();
        exec(OP_AND, 8'hFF); commit();
        if (cy) begin exec(OP_CMC, 8'h00); commit(); end
    endtask

    function automatic string req_of(input logic [3:0] op);
        if (op <= 4'd3)      return "R4";
        else if (op <= 4'd6) return "R5";
        else if (op >= 4'd8 && op <= 4'd11) return "R6";
        else                 return "R7";
    endfunction

    initial begin
        #(CLK_P * 100000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; exec_en = 1'b0; op_sel = '0; operand = '0;
        fetch_t2 = 1'b0; cond_sel = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R1 acc", 32'(acc_out), 32'h0);
        check("R1 flags", 32'(flags_out), 32'h0);

        // Table of operations walked by one loop.
        for (int i = 0; i < NV; i++) begin
            prime(VEC[i][33:26], VEC[i][25]);
            exec(op_t'(VEC[i][24:21]), VEC[i][20:13]);
            commit();
            check(req_of(VEC[i][24:21]), 32'(acc_out), 32'(VEC[i][12:5]));
            check("R12 flags", 32'(flags_out), 32'(VEC[i][4:0]));
        end

        // R2: deferral until fetch_t2.
        prime(8'h00, 1'b0);
        exec(OP_LOAD, 8'h77);
        repeat (3) @(negedge clk);
        check("R2 held before commit", 32'(acc_out), 32'h00);
        commit();
        check("R2 after commit", 32'(acc_out), 32'h77);
        commit();
        check("R2 empty commit", 32'(acc_out), 32'h77);

        // R3: forwarding of a waiting result.
        exec(OP_LOAD, 8'h10);
        exec(OP_ADD, 8'h05);
        commit();
        check("R3 chained", 32'(acc_out), 32'h15);

        // R3: execute and commit on the same edge.
        exec(OP_LOAD, 8'h20);
        @(negedge clk);
        exec_en = 1'b1; op_sel = OP_LOAD; operand = 8'h33; fetch_t2 = 1'b1;
        @(negedge clk);
        exec_en = 1'b0; fetch_t2 = 1'b0;
        check("R3 older committed", 32'(acc_out), 32'h20);
        commit();
        check("R3 newer kept", 32'(acc_out), 32'h33);

        // R8: low correction with carry out of bit 3.
        prime(8'h38, 1'b0);
        exec(OP_ADD, 8'h45); exec(OP_DADJ, 8'h00); commit();
        check("R8 low digit", 32'(acc_out), 32'h83);
        check("R8 flags", 32'(flags_out), 32'b10100);

        // R8: correction forced by AC.
        prime(8'h29, 1'b0);
        exec(OP_ADD, 8'h18); exec(OP_DADJ, 8'h00); commit();
        check("R8 by AC", 32'(acc_out), 32'h47);
        check("R8 by AC flags", 32'(flags_out), 32'b00010);

        // R9: carry forced by CY.
        prime(8'h90, 1'b0);
        exec(OP_ADD, 8'h90); exec(OP_DADJ, 8'h00); commit();
        check("R9 by CY", 32'(acc_out), 32'h80);
        check("R9 by CY flags", 32'(flags_out), 32'b10001);

        // R9: first step carries out of bit 7.
        prime(8'hFA, 1'b0);
        exec(OP_DADJ, 8'h00); commit();
        check("R9 step1 carry", 32'(acc_out), 32'h60);
        check("R9 step1 carry flags", 32'(flags_out), 32'b00111);

        // R9: both digits corrected.
        prime(8'h99, 1'b0);
        exec(OP_ADD, 8'h01); exec(OP_DADJ, 8'h00); commit();
        check("R9 both digits", 32'(acc_out), 32'h00);
        check("R9 both flags", 32'(flags_out), 32'b01111);

        // R10: all codes with Z=1 CY=1 P=1 S=0.
        for (int c = 0; c < 8; c++) begin
            @(negedge clk); cond_sel = 3'(c); #1;
            check("R10 set A", 32'(cond_met), 32'((8'b0110_1010 >> c) & 8'h1));
        end

        // R10: all codes with Z=0 CY=0 P=0 S=1.
        prime(8'h38, 1'b0);
        exec(OP_ADD, 8'h45); exec(OP_DADJ, 8'h00); commit();
        for (int c = 0; c < 8; c++) begin
            @(negedge clk); cond_sel = 3'(c); #1;
            check("R10 set B", 32'(cond_met), 32'((8'b1001_0101 >> c) & 8'h1));
        end

        // R11: condition uses waiting flags before commit.
        exec(OP_CMP, 8'h83);
        @(negedge clk); cond_sel = 3'd1; #1;
        check("R11 Z from waiting", 32'(cond_met), 32'h1);
        check("R11 committed unchanged", 32'(flags_out), 32'b10100);
        commit();
        check("R7 compare keeps A", 32'(acc_out), 32'h83);
        check("R12 compare flags", 32'(flags_out), 32'b01010);

        // R1: reset drops a waiting result.
        exec(OP_LOAD, 8'h5A);
        do_reset();
        check("R1 acc after reset", 32'(acc_out), 32'h00);
        commit();
        check("R1 no waiting after reset", 32'(acc_out), 32'h00);
        check("R1 flags after reset", 32'(flags_out), 32'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule